// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link and turns it into parallel samples in the system clock domain. The three wires are a bit clock, a word clock that selects left or right, and a data line. The bit clock and the word clock are treated as ordinary slow inputs. All three wires pass through two-stage synchronisers, and the block finds bit clock rising edges by comparing the synchronised level with its previous value. The data line and the word clock are read at each of those edges.

Three run-time controls set the framing. The first picks the alignment: I2S, left-justified or right-justified. The second picks the bit order, MSB-first or LSB-first. The third picks the word width: 16, 18, 20 or 24 bits. Each channel half has 32 bit slots, because the bit clock runs at 64 times the sample rate. A received word is sign-extended to 24 bits. After the right word of a frame completes, the left and right outputs update in the same cycle, and a strobe marks that cycle.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `sample_valid` is 0 and both sample outputs are 0.
- R2: With `align_sel` = 0 (I2S), the word begins in the second bit slot after a word clock change, so slot 0 of a half carries no data bit. A low word clock marks the left channel.
- R3: With `align_sel` = 1 (left-justified), the word begins in the slot of the word clock change, and a high word clock marks the left channel.
- R4: With `align_sel` = 2 (right-justified), the last word bit occupies slot 31, the final slot before the next word clock change. A high word clock marks the left channel.
- R5: With `lsb_first` = 0, the first word bit received is the sign bit (bit W-1). With `lsb_first` = 1, the first word bit received is bit 0, and later bits fill upward.
- R6: `width_sel` values 0, 1, 2 and 3 select W = 16, 18, 20 and 24 bits. A word is sign-extended from bit W-1 to 24 bits.
- R7: `sample_valid` is high for exactly one cycle per complete left-then-right frame. Both outputs change only in that cycle and hold their values otherwise.
- R8: The data line has no effect in bit slots outside the selected word, in every alignment.
- R9: Outputs update only in the cycle after a detected bit clock rising edge. Word clock and data activity while the bit clock is still produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Left/right word clock, asynchronous |
| sdata_in | input | 1 | Serial data line |
| align_sel | input | 2 | 0 = I2S, 1 = left-justified, 2 = right-justified |
| lsb_first | input | 1 | 1 = least significant bit sent first |
| width_sel | input | 2 | Word width: 0 = 16, 1 = 18, 2 = 20, 3 = 24 |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| sample_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
The bench sweeps all six alignment and bit-order combinations across all four widths. Each configuration receives four frames, each carrying one of four words: all ones, the sign bit alone, a lone bit 0, and a mixed pattern. The all-ones and sign-bit words distinguish correct sign extension from a width that is off by one. The lone bit 0 and the mixed pattern expose a reversed bit order or a word shifted by one slot, which tells I2S from left-justified alignment. The bench fills the unused slots with changing junk bits, so a right-justified word taken from the wrong end of the half produces visibly wrong samples. A final phase stops the bit clock and toggles the other wires to confirm that nothing is emitted.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SAMPLE_W     = 24;
    localparam int SLOTS_PER_CH = 32;
    localparam int SLOT_W       = $clog2(2 * SLOTS_PER_CH);
    localparam int WSEL_W       = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]   slot_t;

    typedef enum logic [1:0] {
        ALIGN_I2S   = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_RIGHT = 2'd2,
        ALIGN_RSVD  = 2'd3
    } align_e;

    // One bit-clock event as seen by the word assembler
    typedef struct packed {
        logic  strobe;
        slot_t slot;
        logic  is_left;
        logic  new_half;
        logic  bit_val;
    } slot_info_t;

    function automatic slot_t word_len(logic [WSEL_W-1:0] sel);
        case (sel)
            2'd0:    return slot_t'(16);
            2'd1:    return slot_t'(18);
            2'd2:    return slot_t'(20);
            default: return slot_t'(24);
        endcase
    endfunction

    function automatic sample_t sign_fill(sample_t v, logic [WSEL_W-1:0] sel);
        case (sel)
            2'd0:    return {{(SAMPLE_W-16){v[15]}}, v[15:0]};
            2'd1:    return {{(SAMPLE_W-18){v[17]}}, v[17:0]};
            2'd2:    return {{(SAMPLE_W-20){v[19]}}, v[19:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srx_slot_track.sv
module srx_slot_track
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bck_lvl,
    input  logic       wck_lvl,
    input  logic       data_lvl,
    input  align_e     align,
    output logic       bit_rise,
    output slot_info_t info
);
    localparam slot_t SLOT_MAX = '1;

    logic  bck_last;
    logic  primed;
    logic  started;
    logic  wck_prev;
    slot_t slot_cnt;
    logic  trans;
    slot_t cur_slot;

    assign bit_rise = bck_lvl & ~bck_last;
    assign trans    = primed && (wck_lvl != wck_prev);

    always_comb begin
        if (trans)                     cur_slot = '0;
        else if (slot_cnt == SLOT_MAX) cur_slot = SLOT_MAX;
        else                           cur_slot = slot_cnt + slot_t'(1);
    end

    always_comb begin
        info.strobe   = bit_rise && (started || trans);
        info.slot     = cur_slot;
        info.is_left  = (align == ALIGN_I2S) ? ~wck_lvl : wck_lvl;
        info.new_half = trans;
        info.bit_val  = data_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_last <= 1'b0;
            primed   <= 1'b0;
            started  <= 1'b0;
            wck_prev <= 1'b0;
            slot_cnt <= SLOT_MAX;
        end else begin
            bck_last <= bck_lvl;
            if (bit_rise) begin
                primed   <= 1'b1;
                wck_prev <= wck_lvl;
                slot_cnt <= cur_slot;
                if (trans) started <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/srx_assemble.sv
module srx_assemble
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_info_t        info,
    input  align_e            align,
    input  logic              lsb_first,
    input  logic [WSEL_W-1:0] width_sel,
    output sample_t           left_o,
    output sample_t           right_o,
    output logic              valid_o
);
    localparam slot_t SLOTS = slot_t'(SLOTS_PER_CH);
    localparam int    POS_W = $clog2(SAMPLE_W);

    sample_t          acc;
    logic             acc_left;
    logic             acc_live;
    sample_t          left_hold;
    logic             left_ok;

    slot_t            wlen;
    slot_t            first_slot;
    slot_t            k;
    logic             in_word;
    logic [POS_W-1:0] pos;
    sample_t          acc_nx;
    sample_t          done_word;

    always_comb begin
        wlen       = word_len(width_sel);
        first_slot = '0;
        case (align)
            ALIGN_I2S: begin
                in_word = (info.slot != '0) && (info.slot <= wlen);
                k       = info.slot - slot_t'(1);
            end
            ALIGN_RIGHT: begin
                first_slot = SLOTS - wlen;
                in_word    = (info.slot >= first_slot) && (info.slot < SLOTS);
                k          = info.slot - first_slot;
            end
            default: begin
                in_word = info.slot < wlen;
                k       = info.slot;
            end
        endcase
        pos    = lsb_first ? POS_W'(k) : POS_W'(wlen - slot_t'(1) - k);
        acc_nx = info.new_half ? '0 : acc;
        if (in_word) acc_nx[pos] = info.bit_val;
        done_word = sign_fill(acc, width_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            acc_left  <= 1'b0;
            acc_live  <= 1'b0;
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (info.strobe) begin
                acc      <= acc_nx;
                acc_left <= info.is_left;
                acc_live <= 1'b1;
                if (info.new_half && acc_live) begin
                    if (acc_left) begin
                        left_hold <= done_word;
                        left_ok   <= 1'b1;
                    end else if (left_ok) begin
                        left_o  <= left_hold;
                        right_o <= done_word;
                        valid_o <= 1'b1;
                        left_ok <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                sdata_in,
    input  logic [1:0]          align_sel,
    input  logic                lsb_first,
    input  logic [WSEL_W-1:0]   width_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    logic [2:0] sync_q;
    logic       bck_rise;
    slot_info_t info;
    align_e     align;

    assign align = align_e'(align_sel);

    srx_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdata_in, wclk_in, bclk_in}),
        .q   (sync_q)
    );

    srx_slot_track u_track (
        .clk      (clk),
        .rst      (rst),
        .bck_lvl  (sync_q[0]),
        .wck_lvl  (sync_q[1]),
        .data_lvl (sync_q[2]),
        .align    (align),
        .bit_rise (bck_rise),
        .info     (info)
    );

    srx_assemble u_asm (
        .clk       (clk),
        .rst       (rst),
        .info      (info),
        .align     (align),
        .lsb_first (lsb_first),
        .width_sel (width_sel),
        .left_o    (left_out),
        .right_o   (right_out),
        .valid_o   (sample_valid)
    );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        bit_rise,
    input logic        sample_valid,
    input logic [23:0] left_out,
    input logic [23:0] right_out
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!sample_valid && left_out == '0 && right_out == '0));

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> ($stable(left_out) && $stable(right_out)));

    p_after_bitedge_r9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(bit_rise));
endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_rise     (bck_rise),
    .sample_valid (sample_valid),
    .left_out     (left_out),
    .right_out    (right_out)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b0;
    logic        wck = 1'b0;
    logic        sd  = 1'b0;
    logic [1:0]  align_sel = 2'd0;
    logic        lsb_first = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [23:0] got_l [0:15];
    logic [23:0] got_r [0:15];
    int          n_got = 0;
    logic        prev_valid = 1'b0;

    always #5 clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst(rst), .bclk_in(bck), .wclk_in(wck), .sdata_in(sd),
        .align_sel(align_sel), .lsb_first(lsb_first), .width_sel(width_sel),
        .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid)
    );

    // Output monitor; the strobe must never last two cycles (R7)
    always @(negedge clk) begin
        if (!rst && sample_valid) begin
            if (n_got < 16) begin
                got_l[n_got] = left_out;
                got_r[n_got] = right_out;
            end
            n_got++;
        end
        if (!rst && sample_valid && prev_valid) begin
            checks++;
            errors++;
            $display("FAIL R7 strobe high two cycles: actual 2 cycles expected 1");
        end
        prev_valid = sample_valid;
    end

    function automatic int wlen(int ws);
        return (ws == 3) ? 24 : 16 + 2 * ws;
    endfunction

    function automatic logic [23:0] pattern(int f, int w);
        logic [23:0] m;
        m = 24'((32'd1 << w) - 1);
        case (f % 4)
            0:       return m;
            1:       return 24'(32'd1 << (w - 1));
            2:       return 24'd1;
            default: return 24'h5A3C96 & m;
        endcase
    endfunction

    function automatic logic [23:0] sext(logic [23:0] v, int w);
        logic [23:0] m;
        m = 24'((32'd1 << w) - 1);
        return v[w-1] ? (v | ~m) : (v & m);
    endfunction

    // Level of the word clock for a channel half (ch 0 = left)
    function automatic logic lvl(int aln, int ch);
        return (aln == 0) ? (ch == 1) : (ch == 0);
    endfunction

    function automatic logic slot_bit(int aln, bit lsb, int w, int s, int ch,
                                      logic [23:0] v);
        int  k;
        int  lo;
        bit  inw;
        k = 0;
        lo = 32 - w;
        if (aln == 0) begin
            inw = (s >= 1) && (s <= w);
            k = s - 1;
        end else if (aln == 1) begin
            inw = s < w;
            k = s;
        end else begin
            inw = s >= lo;
            k = s - lo;
        end
        if (inw) return v[lsb ? k : w - 1 - k];
        return ((s * 5 + ch * 3) % 4) != 1;   // junk outside the word (R8)
    endfunction

    task automatic send_slot(input logic w, input logic d);
        bck = 1'b0;
        wck = w;
        sd  = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input int aln, input bit lsb, input int w,
                              input logic [23:0] lv, input logic [23:0] rv);
        for (int ch = 0; ch < 2; ch++)
            for (int s = 0; s < 32; s++)
                send_slot(lvl(aln, ch), slot_bit(aln, lsb, w, s, ch, ch == 0 ? lv : rv));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bck = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_got = 0;
    endtask

    task automatic run_config(input int aln, input bit lsb, input int ws);
        int w;
        logic [23:0] lv [0:3];
        logic [23:0] rv [0:3];
        string tag;
        w = wlen(ws);
        tag = (aln == 0) ? "R2" : (aln == 1) ? "R3" : "R4";
        align_sel = 2'(aln);
        lsb_first = lsb;
        width_sel = 2'(ws);
        do_reset();
        for (int i = 0; i < 8; i++) send_slot(lvl(aln, 1), 1'(i % 2));
        for (int f = 0; f < 4; f++) begin
            lv[f] = pattern(f, w);
            rv[f] = pattern(f + 2, w) ^ (24'h000102 & 24'((32'd1 << w) - 1));
            send_frame(aln, lsb, w, lv[f], rv[f]);
        end
        send_frame(aln, lsb, w, 24'd0, 24'd0);
        repeat (6) @(negedge clk);
        checks++;
        if (n_got != 4) begin
            errors++;
            $display("FAIL R7 %s pair count align=%0d lsb=%0d w=%0d: actual %0d expected 4",
                     tag, aln, lsb, w, n_got);
        end
        for (int f = 0; f < 4 && f < n_got; f++) begin
            checks++;
            if (got_l[f] !== sext(lv[f], w) || got_r[f] !== sext(rv[f], w)) begin
                errors++;
                $display("FAIL %s R5 R6 R8 align=%0d lsb=%0d w=%0d frame %0d: actual %h/%h expected %h/%h",
                         tag, aln, lsb, w, f, got_l[f], got_r[f],
                         sext(lv[f], w), sext(rv[f], w));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (sample_valid !== 1'b0 || left_out !== 24'd0 || right_out !== 24'd0) begin
            errors++;
            $display("FAIL R1 reset state: actual %b %h %h expected 0 0 0",
                     sample_valid, left_out, right_out);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (sample_valid !== 1'b0 || left_out !== 24'd0 || right_out !== 24'd0) begin
            errors++;
            $display("FAIL R1 after release: actual %b %h %h expected 0 0 0",
                     sample_valid, left_out, right_out);
        end

        for (int aln = 0; aln < 3; aln++)
            for (int lsb = 0; lsb < 2; lsb++)
                for (int ws = 0; ws < 4; ws++)
                    run_config(aln, 1'(lsb), ws);

        // R9: word clock and data toggle with the bit clock held still
        align_sel = 2'd1;
        do_reset();
        for (int i = 0; i < 300; i++) begin
            wck = 1'(i / 7);
            sd  = 1'(i / 3);
            @(negedge clk);
        end
        checks++;
        if (n_got != 0 || left_out !== 24'd0 || right_out !== 24'd0) begin
            errors++;
            $display("FAIL R9 bit clock still: actual %0d pairs expected 0", n_got);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule